// File: doc/BRIEF.md
# Remote Bus Window Bridge

This block sits on the master side of a crate-to-crate cable and lets local software reach a 64 KB segment of a remote crate's address space as if it were local memory. Three configuration registers are loaded first: a 16-bit window base, a 6-bit address modifier and a window enable. After that, any local access whose upper address half matches a fixed local segment is forwarded over the cable. The remote address is formed from the window base and the low 16 bits of the local address. The remote cycle carries the same direction and the programmed modifier.

Each forwarded cycle is fully interlocked. The block raises strobe and waits for the acknowledge after it has passed a glitch filter. It drops strobe and waits for the filtered acknowledge to fall, then reports completion with the read data. If no acknowledge arrives, a watchdog ends the cycle with an error. Moving the window to another segment takes a single write of a new base value.

Top module: `rbus_window_bridge`

## Requirements
- R1: After reset the window base, the address modifier and the window enable are all zero, strobe is low and no completion is signalled.
- R2: With the window enabled, an access whose address bits [31:16] equal the local segment parameter (default 16'h00C0) starts one remote cycle whose address is {window base, access address[15:0]}.
- R3: A forwarded cycle presents the programmed address modifier on `rb_am`, the access direction on `rb_wr` (1 = write), and, for writes, the access write data on `rb_wdata`.
- R4: One configuration write of select code 0 (base, cfg_wdata[15:0]) moves the window, and the next forwarded access uses the new upper address bits. Select code 1 loads the modifier from cfg_wdata[5:0]. Select code 2 loads the enable from cfg_wdata[0].
- R5: An access while the window is disabled, or outside the local segment, produces `acc_done` together with `acc_err` in the clock cycle after the request, with no strobe.
- R6: Strobe stays high until the filtered acknowledge is seen. Read data present with that acknowledge is returned on `acc_rdata`. `acc_done` with `acc_err` low follows once the filtered acknowledge has fallen.
- R7: The acknowledge filter changes its output only after the raw line has held the new level for 3 consecutive clock samples. An acknowledge pulse of 2 cycles is ignored, and one of 3 cycles is accepted.
- R8: If no filtered acknowledge arrives, strobe is dropped after exactly 256 cycles high, `acc_done` and `acc_err` are raised together, and the block accepts the next access.
- R9: Remote address, modifier, direction and write data stay stable while strobe is high, and `acc_done` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 base, 1 modifier, 2 enable |
| cfg_wdata | input | 16 | Configuration write data |
| acc_req | input | 1 | Local access request, one cycle, taken when idle |
| acc_we | input | 1 | Access direction, 1 = write |
| acc_addr | input | 32 | Local access address |
| acc_wdata | input | 32 | Local write data |
| acc_done | output | 1 | Access completion pulse |
| acc_err | output | 1 | Completion with error (miss or timeout) |
| acc_rdata | output | 32 | Read data of the last completed read |
| rb_stb | output | 1 | Cable strobe |
| rb_wr | output | 1 | Cable direction, 1 = write |
| rb_am | output | 6 | Cable address modifier |
| rb_addr | output | 32 | Cable address |
| rb_wdata | output | 32 | Cable write data |
| rb_rdata | input | 32 | Cable read data |
| rb_ack | input | 1 | Raw cable acknowledge |

## Verification
A miss completes in the cycle after the request edge. Strobe rises one cycle after an accepted request. A quiet acknowledge keeps strobe high for 256 cycles, and the bench counts those cycles instead of waiting a fixed time. Successful completions depend on the responder's delay plus three filter samples for each acknowledge edge. The driver therefore pushes the expected results into queues, and monitors sampling on the falling clock edge pop them when strobe rises or `acc_done` pulses. The exact arrival cycle does not matter, only the order and the values.

// File: rtl/rwin_pkg.sv
package rwin_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_STB  = 2'd1,
    ST_REL  = 2'd2
  } hs_state_t;

  localparam logic [1:0] SEL_BASE = 2'd0;
  localparam logic [1:0] SEL_AM   = 2'd1;
  localparam logic [1:0] SEL_EN   = 2'd2;
endpackage

// File: rtl/rwin_glitch_filter.sv
module rwin_glitch_filter #(
  parameter int DEPTH = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic filt
);
  logic [DEPTH-1:0] smp_q, smp_n;
  logic             filt_q, filt_n;

  always_comb begin
    smp_n  = {smp_q[DEPTH-2:0], raw};
    filt_n = filt_q;
    if (&smp_q)       filt_n = 1'b1;
    else if (~|smp_q) filt_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q  <= '0;
      filt_q <= 1'b0;
    end else begin
      smp_q  <= smp_n;
      filt_q <= filt_n;
    end
  end

  assign filt = filt_q;

  generate
    if (DEPTH == 3) begin : g_chk
      // R7
      filt_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(filt_q) |-> ($past(raw, 2) && $past(raw, 3) && $past(raw, 4)));
      // R7
      filt_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(filt_q) |-> (!$past(raw, 2) && !$past(raw, 3) && !$past(raw, 4)));
    end
  endgenerate
endmodule

// File: rtl/rwin_cfg_regs.sv
module rwin_cfg_regs #(
  parameter int BASE_W = 16,
  parameter int AM_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [15:0]       cfg_wdata,
  output logic [BASE_W-1:0] base,
  output logic [AM_W-1:0]   am,
  output logic              en
);
  import rwin_pkg::*;

  logic [BASE_W-1:0] base_q;
  logic [AM_W-1:0]   am_q;
  logic              en_q;
  logic              base_ce, am_ce, en_ce;

  always_comb begin
    base_ce = cfg_we && (cfg_sel == SEL_BASE);
    am_ce   = cfg_we && (cfg_sel == SEL_AM);
    en_ce   = cfg_we && (cfg_sel == SEL_EN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      am_q   <= '0;
      en_q   <= 1'b0;
    end else begin
      if (base_ce) base_q <= cfg_wdata[BASE_W-1:0];
      if (am_ce)   am_q   <= cfg_wdata[AM_W-1:0];
      if (en_ce)   en_q   <= cfg_wdata[0];
    end
  end

  assign base = base_q;
  assign am   = am_q;
  assign en   = en_q;
endmodule

// File: rtl/rwin_decode.sv
module rwin_decode #(
  parameter int          AW      = 32,
  parameter int          OFF_W   = 16,
  parameter logic [15:0] SEG     = 16'h00C0
) (
  input  logic               en,
  input  logic [AW-OFF_W-1:0] base,
  input  logic [AW-1:0]      addr,
  output logic               hit,
  output logic [AW-1:0]      raddr
);
  always_comb begin
    hit   = en && (addr[AW-1:OFF_W] == SEG[AW-OFF_W-1:0]);
    raddr = {base, addr[OFF_W-1:0]};
  end
endmodule

// File: rtl/rwin_handshake.sv
module rwin_handshake #(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int AM_W = 6,
  parameter int TMO  = 256
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req,
  input  logic            hit,
  input  logic            we,
  input  logic [AW-1:0]   raddr,
  input  logic [AM_W-1:0] am,
  input  logic [DW-1:0]   wdata,
  input  logic            ack_f,
  input  logic [DW-1:0]   rb_rdata,
  output logic            rb_stb,
  output logic            rb_wr,
  output logic [AM_W-1:0] rb_am,
  output logic [AW-1:0]   rb_addr,
  output logic [DW-1:0]   rb_wdata,
  output logic            done,
  output logic            err,
  output logic [DW-1:0]   rdata
);
  import rwin_pkg::*;

  localparam int            CW       = $clog2(TMO);
  localparam logic [CW-1:0] CNT_LAST = CW'(TMO - 1);

  hs_state_t       st_q, st_n;
  logic [CW-1:0]   cnt_q, cnt_n;
  logic            done_q, done_n, err_q, err_n;
  logic            lat_ce, cap_ce;
  logic [AW-1:0]   addr_q;
  logic [AM_W-1:0] am_q;
  logic            wr_q;
  logic [DW-1:0]   wdata_q, rdata_q;

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    done_n = 1'b0;
    err_n  = 1'b0;
    lat_ce = 1'b0;
    cap_ce = 1'b0;
    unique case (st_q)
      ST_IDLE: if (req) begin
        if (hit) begin
          st_n   = ST_STB;
          cnt_n  = '0;
          lat_ce = 1'b1;
        end else begin
          done_n = 1'b1;
          err_n  = 1'b1;
        end
      end
      ST_STB: begin
        if (ack_f) begin
          st_n   = ST_REL;
          cap_ce = !wr_q;
        end else if (cnt_q == CNT_LAST) begin
          st_n   = ST_IDLE;
          done_n = 1'b1;
          err_n  = 1'b1;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      ST_REL: if (!ack_f) begin
        st_n   = ST_IDLE;
        done_n = 1'b1;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      addr_q  <= '0;
      am_q    <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      done_q <= done_n;
      err_q  <= err_n;
      if (lat_ce) begin
        addr_q  <= raddr;
        am_q    <= am;
        wr_q    <= we;
        wdata_q <= wdata;
      end
      if (cap_ce) rdata_q <= rb_rdata;
    end
  end

  assign rb_stb   = (st_q == ST_STB);
  assign rb_wr    = wr_q;
  assign rb_am    = am_q;
  assign rb_addr  = addr_q;
  assign rb_wdata = wdata_q;
  assign done     = done_q;
  assign err      = err_q;
  assign rdata    = rdata_q;

  // R5
  miss_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && req && !hit) |=> (done_q && err_q && !rb_stb));
  // R6
  stb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_stb && !ack_f && cnt_q != CNT_LAST) |=> rb_stb);
  // R8
  tmo_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_stb && !ack_f && cnt_q == CNT_LAST) |=> (done_q && err_q && !rb_stb));
  // R9
  cable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_stb && $past(rb_stb)) |-> ($stable(addr_q) && $stable(am_q) && $stable(wr_q) && $stable(wdata_q)));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
endmodule

// File: rtl/rbus_window_bridge.sv
module rbus_window_bridge #(
  parameter int          AW       = 32,
  parameter int          DW       = 32,
  parameter int          OFF_W    = 16,
  parameter int          AM_W     = 6,
  parameter int          TMO      = 256,
  parameter int          FLT_LEN  = 3,
  parameter logic [15:0] LOC_SEG  = 16'h00C0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_sel,
  input  logic [15:0]     cfg_wdata,
  input  logic            acc_req,
  input  logic            acc_we,
  input  logic [AW-1:0]   acc_addr,
  input  logic [DW-1:0]   acc_wdata,
  output logic            acc_done,
  output logic            acc_err,
  output logic [DW-1:0]   acc_rdata,
  output logic            rb_stb,
  output logic            rb_wr,
  output logic [AM_W-1:0] rb_am,
  output logic [AW-1:0]   rb_addr,
  output logic [DW-1:0]   rb_wdata,
  input  logic [DW-1:0]   rb_rdata,
  input  logic            rb_ack
);
  localparam int BASE_W = AW - OFF_W;

  logic [BASE_W-1:0] base;
  logic [AM_W-1:0]   am;
  logic              en, hit, ack_f;
  logic [AW-1:0]     raddr;

  rwin_cfg_regs #(.BASE_W(BASE_W), .AM_W(AM_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .base(base), .am(am), .en(en)
  );

  rwin_decode #(.AW(AW), .OFF_W(OFF_W), .SEG(LOC_SEG)) u_dec (
    .en(en), .base(base), .addr(acc_addr), .hit(hit), .raddr(raddr)
  );

  rwin_glitch_filter #(.DEPTH(FLT_LEN)) u_ack_flt (
    .clk(clk), .rst_n(rst_n), .raw(rb_ack), .filt(ack_f)
  );

  rwin_handshake #(.AW(AW), .DW(DW), .AM_W(AM_W), .TMO(TMO)) u_hs (
    .clk(clk), .rst_n(rst_n), .req(acc_req), .hit(hit), .we(acc_we),
    .raddr(raddr), .am(am), .wdata(acc_wdata), .ack_f(ack_f),
    .rb_rdata(rb_rdata), .rb_stb(rb_stb), .rb_wr(rb_wr), .rb_am(rb_am),
    .rb_addr(rb_addr), .rb_wdata(rb_wdata), .done(acc_done),
    .err(acc_err), .rdata(acc_rdata)
  );
endmodule

// File: tb/rbus_window_bridge_bench.sv
module rbus_window_bridge_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic        acc_req = 1'b0, acc_we = 1'b0;
  logic [31:0] acc_addr = '0, acc_wdata = '0;
  logic        acc_done, acc_err, rb_stb, rb_wr;
  logic [31:0] acc_rdata, rb_addr, rb_wdata;
  logic [5:0]  rb_am;
  logic [31:0] rb_rdata = '0;
  logic        rb_ack = 1'b0;

  int checks = 0, fails = 0;
  int mode = 0;
  int stb_len = 0;
  logic [31:0] resp_data = '0;
  logic        stb_prev = 1'b0;
  logic [31:0] cur_addr;

  logic [31:0] q_addr[$], q_wdata[$], q_rdata[$];
  logic [5:0]  q_am[$];
  logic        q_wr[$], q_err[$], q_chkrd[$];

  always #10 clk = ~clk;

  rbus_window_bridge u_rbus_window_bridge (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .acc_req(acc_req), .acc_we(acc_we),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_done(acc_done),
    .acc_err(acc_err), .acc_rdata(acc_rdata), .rb_stb(rb_stb),
    .rb_wr(rb_wr), .rb_am(rb_am), .rb_addr(rb_addr), .rb_wdata(rb_wdata),
    .rb_rdata(rb_rdata), .rb_ack(rb_ack)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // remote-cycle monitor: R2 R3 on strobe rise, R9 while held
  always @(negedge clk) begin
    if (rb_stb) stb_len++;
    if (rb_stb && !stb_prev) begin
      cur_addr = rb_addr;
      if (q_addr.size() == 0) begin
        chk(1'b0, "R5 unexpected strobe", 32'd1, 32'd0);
      end else begin
        logic [31:0] ea, ed; logic [5:0] em; logic ew;
        ea = q_addr.pop_front(); em = q_am.pop_front();
        ew = q_wr.pop_front();   ed = q_wdata.pop_front();
        chk(rb_addr == ea, "R2 remote address", rb_addr, ea);
        chk(rb_am == em, "R3 modifier", {26'd0, rb_am}, {26'd0, em});
        chk(rb_wr == ew, "R3 direction", {31'd0, rb_wr}, {31'd0, ew});
        if (ew) chk(rb_wdata == ed, "R3 write data", rb_wdata, ed);
      end
    end else if (rb_stb && rb_addr != cur_addr) begin
      chk(1'b0, "R9 address moved under strobe", rb_addr, cur_addr);
    end
    stb_prev = rb_stb;
  end

  // completion monitor: R5 R6 R8
  always @(negedge clk) begin
    if (acc_done) begin
      if (q_err.size() == 0) begin
        chk(1'b0, "R9 unexpected completion", 32'd1, 32'd0);
      end else begin
        logic ee, cr; logic [31:0] er;
        ee = q_err.pop_front(); cr = q_chkrd.pop_front(); er = q_rdata.pop_front();
        chk(acc_err == ee, "R5/R8 error flag", {31'd0, acc_err}, {31'd0, ee});
        if (cr) chk(acc_rdata == er, "R6 read data", acc_rdata, er);
      end
    end
  end

  // remote responder
  initial begin
    forever begin
      @(negedge clk);
      if (rb_stb) begin
        if (mode == 0) begin
          repeat (2) @(negedge clk);
          rb_rdata = resp_data; rb_ack = 1'b1;
          while (rb_stb) @(negedge clk);
          rb_ack = 1'b0;
        end else if (mode == 1) begin
          rb_ack = 1'b1;
          repeat (2) @(negedge clk);
          rb_ack = 1'b0;
          while (rb_stb) @(negedge clk);
        end else begin
          rb_rdata = resp_data; rb_ack = 1'b1;
          repeat (3) @(negedge clk);
          rb_ack = 1'b0;
          while (rb_stb) @(negedge clk);
        end
        repeat (4) @(negedge clk);
      end
    end
  end

  task automatic cfg_write(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // driver: pushes expectations, issues the request, waits for completion
  task automatic access(input logic we, input logic [31:0] a, input logic [31:0] d,
                        input bit fwd, input logic [31:0] ea, input logic [5:0] em,
                        input bit eerr, input logic [31:0] rd);
    if (fwd) begin
      q_addr.push_back(ea); q_am.push_back(em); q_wr.push_back(we); q_wdata.push_back(d);
    end
    q_err.push_back(eerr); q_chkrd.push_back(!we && !eerr); q_rdata.push_back(rd);
    resp_data = rd;
    @(negedge clk);
    stb_len = 0;
    acc_req = 1'b1; acc_we = we; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_req = 1'b0;
    if (!fwd) begin
      chk(acc_done && acc_err && !rb_stb, "R5 miss in next cycle", {31'd0, acc_done}, 32'd1);
    end
    while (!acc_done) @(negedge clk);
    @(negedge clk);
    chk(!acc_done, "R9 done single pulse", {31'd0, acc_done}, 32'd0);
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rb_stb, "R1 strobe low after reset", {31'd0, rb_stb}, 32'd0);
    chk(!acc_done, "R1 no done after reset", {31'd0, acc_done}, 32'd0);
    // R1: window disabled after reset -> miss
    access(1'b0, 32'h00C0_0010, '0, 0, '0, '0, 1'b1, '0);
    // R1 base/modifier zero, R2 hit
    cfg_write(2'd2, 16'h0001);
    access(1'b0, 32'h00C0_5A5A, '0, 1, 32'h0000_5A5A, 6'h00, 1'b0, 32'hCAFE_0001);
    // R3 R4 write with programmed base and modifier
    cfg_write(2'd0, 16'h1234);
    cfg_write(2'd1, 16'h003D);
    access(1'b1, 32'h00C0_ABCD, 32'hDEAD_BEEF, 1, 32'h1234_ABCD, 6'h3D, 1'b0, '0);
    // R6 read data returned
    access(1'b0, 32'h00C0_0004, '0, 1, 32'h1234_0004, 6'h3D, 1'b0, 32'h8765_4321);
    // R4 move window with one write
    cfg_write(2'd0, 16'h0077);
    access(1'b0, 32'h00C0_FFFC, '0, 1, 32'h0077_FFFC, 6'h3D, 1'b0, 32'h0F0F_A5A5);
    // R5 outside the segment
    access(1'b1, 32'h00C1_0000, 32'h1, 0, '0, '0, 1'b1, '0);
    // R7 R8 two-cycle glitch ignored -> timeout
    mode = 1;
    access(1'b0, 32'h00C0_0100, '0, 1, 32'h0077_0100, 6'h3D, 1'b1, '0);
    chk(stb_len == 256, "R8 strobe length before timeout", stb_len, 32'd256);
    // R7 three-cycle pulse accepted
    mode = 2;
    access(1'b0, 32'h00C0_0200, '0, 1, 32'h0077_0200, 6'h3D, 1'b0, 32'h1357_9BDF);
    // R8 back to normal service after timeout
    mode = 0;
    access(1'b1, 32'h00C0_0300, 32'h2468_ACE0, 1, 32'h0077_0300, 6'h3D, 1'b0, '0);
    // R4 disable via select code 2
    cfg_write(2'd2, 16'h0000);
    access(1'b0, 32'h00C0_0300, '0, 0, '0, '0, 1'b1, '0);
    chk(q_addr.size() == 0 && q_err.size() == 0, "R2 all expected items consumed",
        q_addr.size() + q_err.size(), 32'd0);
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule